// File: doc/BRIEF.md
# Register-Mapped SPI Host Front End

This block is a 32-bit register slave placed in front of a serial shift engine. Software queues bytes into a transmit queue through a data register. Whenever the inhibit flag in the control register is clear, the block sends the queued bytes to the shift engine one at a time. For each byte it pulses a start strobe with the byte, waits for the engine's done strobe, and stores the returned byte in a receive queue. Software reads that queue through a second data register. A chip-select register drives one active-low select line per attached slave.

Both queues are byte-wide and `FIFO_DEPTH` entries deep (default 256). Status, occupancy and control words can be read back. Each queue can be flushed on its own by a write-only control bit. A keyed write resets the whole block. Two single-cycle event pulses go to an external interrupt block: one when a returned byte is stored, one when a returned byte is lost because the receive queue was full.

Top module: `spiHostRegs`

## Requirements
- R1: After reset, these read values hold: status (byte offset 0x64) reads 0x5, control (0x60) reads 0, both occupancy words read 0, the slave-select word (0x70) reads all ones, and every `chipSel` line is high.
- R2: A write to offset 0x68 queues the low 8 bits of the written word. Queued bytes go out in write order. Each byte appears on `xchgTxByte` while `xchgStart` pulses. The byte on `xchgRxByte` at `xchgDone` is stored, and reads of offset 0x6C return the stored bytes in order in bits 7:0 with the upper bits zero.
- R3: While control bit 8 is 1, no new exchange starts. A control write that leaves bit 8 at 0 lets any bytes still queued go out.
- R4: The status word uses bit 3 for transmit queue full, bit 2 for transmit queue empty, bit 1 for receive queue full and bit 0 for receive queue empty. Writes to the status offset change nothing.
- R5: A write to 0x68 while the transmit queue is full is dropped and leaves the queued bytes unchanged.
- R6: A read of 0x6C while the receive queue is empty returns 0xDEADBEEF and changes no state.
- R7: A byte returned while the receive queue is full is discarded, and `evtOverrun` pulses for one cycle. Each stored byte pulses `evtRxStored`.
- R8: Writing control bit 5 as 1 empties the transmit queue. Writing bit 6 as 1 empties the receive queue. Neither bit is kept, so both read back as 0.
- R9: Each `chipSel[i]` follows bit i of the slave-select word at 0x70, so a 0 selects slave i.
- R10: Offsets 0x74 (transmit) and 0x78 (receive) read the queue's entry count minus one, and read 0 for an empty queue.
- R11: Writing exactly 0x0000000A to offset 0x40 returns every register and both queues to the R1 state. Any other value written there has no effect.
- R12: At most one exchange is in flight. `xchgStart` is a single-cycle pulse, and it does not pulse again until `xchgDone` has closed the current exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (pops the receive queue at 0x6C) |
| busAddr | input | 7 | Byte address of the 32-bit register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid in the same cycle as busRdEn |
| xchgStart | output | 1 | One-cycle pulse that starts a byte exchange |
| xchgTxByte | output | 8 | Byte to shift out, valid while xchgStart is high |
| xchgDone | input | 1 | Shift engine finished the exchange |
| xchgRxByte | input | 8 | Byte shifted in, valid with xchgDone |
| chipSel | output | NUM_CS | Active-low slave selects |
| evtRxStored | output | 1 | Pulse: a returned byte was stored |
| evtOverrun | output | 1 | Pulse: a returned byte was dropped |

## Verification
The exchange path is swept over all 256 byte values through a responder that returns the inverted byte XOR 0x3C. This separates lost bits, a wrong byte lane and swapped directions. Queue ordering is tested by holding a full transmit burst behind the inhibit flag and then releasing it. This checks write order, the drop of the extra write, the full and empty flags, and the empty-read marker. A small queue depth makes the fill-to-overrun pattern short, so the first four bytes are seen to survive and the fifth to raise the drop event. The flush bits and the reset key are each tried against a loaded state, once with a wrong key and once with the right one, to show what each one clears and what it leaves alone.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  // word indices (byte offset / 4); software depends on these
  localparam logic [4:0] IDX_KEY    = 5'h10;
  localparam logic [4:0] IDX_CTRL   = 5'h18;
  localparam logic [4:0] IDX_STAT   = 5'h19;
  localparam logic [4:0] IDX_TXDATA = 5'h1A;
  localparam logic [4:0] IDX_RXDATA = 5'h1B;
  localparam logic [4:0] IDX_SEL    = 5'h1C;
  localparam logic [4:0] IDX_TXOCC  = 5'h1D;
  localparam logic [4:0] IDX_RXOCC  = 5'h1E;

  localparam int CTRL_TXFLUSH = 5;
  localparam int CTRL_RXFLUSH = 6;
  localparam int CTRL_INHIBIT = 8;

  localparam logic [31:0] RESET_KEY   = 32'h0000_000A;
  localparam logic [31:0] EMPTY_MARK  = 32'hDEAD_BEEF;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
    logic rxFlush;
    logic selWrite;
    logic softRst;
  } hostStrobes_t;
endpackage

// File: rtl/spiHostFifo.sv
module spiHostFifo #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrByte,
  output logic [WIDTH-1:0] headByte,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign headByte = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wrByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (push && !flush) |-> !full);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !flush) |-> !empty);
endmodule

// File: rtl/spiHostCtrl.sv
module spiHostCtrl
  import spi_host_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         busWrEn,
  input  logic         busRdEn,
  input  logic [4:0]   wordIdx,
  input  logic [31:0]  busWrData,
  input  logic         txFull,
  input  logic         txEmpty,
  input  logic         rxFull,
  input  logic         rxEmpty,
  input  logic         xchgDone,
  output hostStrobes_t stb,
  output logic [31:0]  ctrlReg,
  output logic         xchgStart,
  output logic         evtRxStored,
  output logic         evtOverrun
);
  typedef enum logic {S_IDLE, S_WAIT} xchgState_t;
  xchgState_t state;

  logic inhibit;
  logic ctrlWr;
  logic closeXchg;

  assign inhibit   = ctrlReg[CTRL_INHIBIT];
  assign ctrlWr    = busWrEn && (wordIdx == IDX_CTRL);
  assign closeXchg = (state == S_WAIT) && xchgDone;

  always_comb begin
    stb          = '0;
    stb.softRst  = busWrEn && (wordIdx == IDX_KEY) && (busWrData == RESET_KEY);
    stb.txFlush  = stb.softRst || (ctrlWr && busWrData[CTRL_TXFLUSH]);
    stb.rxFlush  = stb.softRst || (ctrlWr && busWrData[CTRL_RXFLUSH]);
    stb.txPush   = busWrEn && (wordIdx == IDX_TXDATA) && !txFull;
    stb.rxPop    = busRdEn && (wordIdx == IDX_RXDATA) && !rxEmpty;
    stb.selWrite = busWrEn && (wordIdx == IDX_SEL);
    stb.txPop    = (state == S_IDLE) && !inhibit && !txEmpty && !stb.txFlush;
    stb.rxPush   = closeXchg && !rxFull && !stb.rxFlush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (stb.softRst) begin
      ctrlReg <= '0;
    end else if (ctrlWr) begin
      ctrlReg <= busWrData & ~((32'd1 << CTRL_TXFLUSH) | (32'd1 << CTRL_RXFLUSH));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      xchgStart   <= 1'b0;
      evtRxStored <= 1'b0;
      evtOverrun  <= 1'b0;
    end else if (stb.softRst) begin
      state       <= S_IDLE;
      xchgStart   <= 1'b0;
      evtRxStored <= 1'b0;
      evtOverrun  <= 1'b0;
    end else begin
      evtRxStored <= stb.rxPush;
      evtOverrun  <= closeXchg && rxFull;
      xchgStart   <= stb.txPop;
      case (state)
        S_IDLE:  if (stb.txPop) state <= S_WAIT;
        S_WAIT:  if (xchgDone)  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    xchgStart |=> !xchgStart);
  assert_start_in_wait_R12: assert property (@(posedge clk) disable iff (!rstN)
    xchgStart |-> (state == S_WAIT));
  assert_inhibit_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xchgStart) |-> !$past(inhibit));
  assert_event_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(evtOverrun && evtRxStored));
endmodule

// File: rtl/spiHostData.sv
module spiHostData
  import spi_host_pkg::*;
#(
  parameter int FIFO_DEPTH = 256,
  parameter int NUM_CS = 1,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobes_t      stb,
  input  logic [4:0]        wordIdx,
  input  logic [31:0]       busWrData,
  input  logic [31:0]       ctrlReg,
  input  logic [7:0]        xchgRxByte,
  output logic [31:0]       busRdData,
  output logic [7:0]        xchgTxByte,
  output logic [NUM_CS-1:0] chipSel,
  output logic              txFull,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxEmpty
);
  logic [7:0]       txHead, rxHead;
  logic [CNT_W-1:0] txCount, rxCount;
  logic [CNT_W-1:0] txOcc, rxOcc;
  logic [NUM_CS-1:0] selReg;
  logic [31:0]      statWord;

  spiHostFifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) uTxFifo (
    .clk(clk), .rstN(rstN), .flush(stb.txFlush), .push(stb.txPush), .pop(stb.txPop),
    .wrByte(busWrData[7:0]), .headByte(txHead), .count(txCount),
    .full(txFull), .empty(txEmpty)
  );

  spiHostFifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) uRxFifo (
    .clk(clk), .rstN(rstN), .flush(stb.rxFlush), .push(stb.rxPush), .pop(stb.rxPop),
    .wrByte(xchgRxByte), .headByte(rxHead), .count(rxCount),
    .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xchgTxByte <= '0;
    end else if (stb.txPop) begin
      xchgTxByte <= txHead;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '1;
    end else if (stb.softRst) begin
      selReg <= '1;
    end else if (stb.selWrite) begin
      selReg <= busWrData[NUM_CS-1:0];
    end
  end

  assign chipSel  = selReg;
  assign txOcc    = txEmpty ? '0 : txCount - 1'b1;
  assign rxOcc    = rxEmpty ? '0 : rxCount - 1'b1;
  assign statWord = {28'd0, txFull, txEmpty, rxFull, rxEmpty};

  always_comb begin
    busRdData = '0;
    case (wordIdx)
      IDX_CTRL:   busRdData = ctrlReg;
      IDX_STAT:   busRdData = statWord;
      IDX_RXDATA: busRdData = rxEmpty ? EMPTY_MARK : {24'd0, rxHead};
      IDX_SEL:    busRdData = 32'(selReg);
      IDX_TXOCC:  busRdData = 32'(txOcc);
      IDX_RXOCC:  busRdData = 32'(rxOcc);
      default:    busRdData = '0;
    endcase
  end

  assert_flags_consistent_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(txFull && txEmpty) && !(rxFull && rxEmpty));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxFlush |=> rxEmpty);
endmodule

// File: rtl/spiHostRegs.sv
module spiHostRegs
  import spi_host_pkg::*;
#(
  parameter int FIFO_DEPTH = 256,
  parameter int NUM_CS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [6:0]        busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              xchgStart,
  output logic [7:0]        xchgTxByte,
  input  logic              xchgDone,
  input  logic [7:0]        xchgRxByte,
  output logic [NUM_CS-1:0] chipSel,
  output logic              evtRxStored,
  output logic              evtOverrun
);
  hostStrobes_t stb;
  logic [4:0]   wordIdx;
  logic [31:0]  ctrlReg;
  logic         txFull, txEmpty, rxFull, rxEmpty;
  logic [1:0]   unusedLow;

  assign wordIdx   = busAddr[6:2];
  assign unusedLow = busAddr[1:0];

  spiHostCtrl uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .wordIdx(wordIdx), .busWrData(busWrData),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .xchgDone(xchgDone), .stb(stb), .ctrlReg(ctrlReg), .xchgStart(xchgStart),
    .evtRxStored(evtRxStored), .evtOverrun(evtOverrun)
  );

  spiHostData #(.FIFO_DEPTH(FIFO_DEPTH), .NUM_CS(NUM_CS)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wordIdx(wordIdx), .busWrData(busWrData),
    .ctrlReg(ctrlReg), .xchgRxByte(xchgRxByte), .busRdData(busRdData),
    .xchgTxByte(xchgTxByte), .chipSel(chipSel),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty)
  );
endmodule

// File: tb/tb_spiHostRegs.sv
`timescale 1ns/1ps
module tb_spiHostRegs;
  localparam int DEPTH = 4;
  localparam int NCS = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [6:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic xchgStart;
  logic [7:0] xchgTxByte;
  logic xchgDone = 1'b0;
  logic [7:0] xchgRxByte = '0;
  logic [NCS-1:0] chipSel;
  logic evtRxStored, evtOverrun;

  int checks = 0, fails = 0;
  int startCnt = 0, overrunCnt = 0, storedCnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spiHostRegs #(.FIFO_DEPTH(DEPTH), .NUM_CS(NCS)) dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .xchgStart(xchgStart),
    .xchgTxByte(xchgTxByte), .xchgDone(xchgDone), .xchgRxByte(xchgRxByte),
    .chipSel(chipSel), .evtRxStored(evtRxStored), .evtOverrun(evtOverrun)
  );

  function automatic logic [7:0] respond(input logic [7:0] v);
    return ~v ^ 8'h3C;
  endfunction

  // shift-engine model: answers two cycles after each start
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && xchgStart) begin
        automatic logic [7:0] seen = xchgTxByte;
        startCnt++;
        repeat (2) @(negedge clk);
        xchgDone = 1'b1;
        xchgRxByte = respond(seen);
        @(negedge clk);
        xchgDone = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && evtOverrun) overrunCnt++;
    if (rstN && evtRxStored) storedCnt++;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #2 d = busRdData;
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic expectRd(input string req, input logic [6:0] a, input logic [31:0] e);
    logic [31:0] v;
    rd(a, v);
    check(req, v, e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    expectRd("R1 status", 7'h64, 32'h5);
    expectRd("R1 ctrl", 7'h60, 32'h0);
    expectRd("R1 txocc", 7'h74, 32'h0);
    expectRd("R1 rxocc", 7'h78, 32'h0);
    expectRd("R1 select", 7'h70, 32'h7);
    check("R1 chipSel", 32'(chipSel), 32'h7);

    // R2 exhaustive byte sweep through the exchange path
    for (int v = 0; v < 256; v++) begin
      wr(7'h68, 32'hABCD_0000 | 32'(v));
      idle(8);
      expectRd("R2 returned byte", 7'h6C, 32'(respond(8'(v))));
    end
    check("R2 start count", 32'(startCnt), 32'd256);
    check("R7 stored events", 32'(storedCnt), 32'd256);

    // R3/R5/R4/R10: queue a full burst behind inhibit
    wr(7'h60, 32'h100);
    expectRd("R3 ctrl readback", 7'h60, 32'h100);
    s0 = startCnt;
    for (int n = 1; n <= DEPTH; n++) begin
      wr(7'h68, 32'(8'hA0 + n - 1));
      expectRd("R10 txocc", 7'h74, 32'(n - 1));
    end
    wr(7'h68, 32'hA9);              // dropped: R5
    idle(6);
    check("R3 no start while inhibited", 32'(startCnt), 32'(s0));
    expectRd("R5 txocc after drop", 7'h74, 32'(DEPTH - 1));
    expectRd("R4 status tx full", 7'h64, 32'h9);
    wr(7'h64, 32'hF);
    expectRd("R4 status write ignored", 7'h64, 32'h9);
    wr(7'h60, 32'h0);               // release
    idle(40);
    check("R3 drained after release", 32'(startCnt), 32'(s0 + DEPTH));
    expectRd("R10 rxocc", 7'h78, 32'(DEPTH - 1));
    expectRd("R4 status rx full", 7'h64, 32'h6);
    for (int n = 0; n < DEPTH; n++)
      expectRd("R2 order", 7'h6C, 32'(respond(8'(8'hA0 + n))));
    expectRd("R6 empty mark", 7'h6C, 32'hDEADBEEF);
    expectRd("R6 status unchanged", 7'h64, 32'h5);
    expectRd("R6 rxocc unchanged", 7'h78, 32'h0);

    // R7 overrun
    s0 = overrunCnt;
    for (int n = 0; n <= DEPTH; n++) begin
      wr(7'h68, 32'(8'h50 + n));
      idle(8);
    end
    check("R7 overrun pulse", 32'(overrunCnt), 32'(s0 + 1));
    for (int n = 0; n < DEPTH; n++)
      expectRd("R7 kept bytes", 7'h6C, 32'(respond(8'(8'h50 + n))));
    expectRd("R7 dropped byte gone", 7'h6C, 32'hDEADBEEF);

    // R8 flush bits
    wr(7'h68, 32'h11); idle(8);
    wr(7'h68, 32'h22); idle(8);
    wr(7'h60, 32'h100);
    wr(7'h68, 32'h33); wr(7'h68, 32'h44); wr(7'h68, 32'h55);
    wr(7'h60, 32'h120);
    expectRd("R8 tx flushed", 7'h64, 32'h4);
    expectRd("R8 rx kept", 7'h78, 32'h1);
    expectRd("R8 bits read 0", 7'h60, 32'h100);
    wr(7'h60, 32'h140);
    expectRd("R8 rx flushed", 7'h64, 32'h5);
    s0 = startCnt;
    wr(7'h60, 32'h0);
    idle(6);
    check("R8 nothing left to send", 32'(startCnt), 32'(s0));

    // R9 chip selects
    wr(7'h70, 32'h5);
    check("R9 chipSel 101", 32'(chipSel), 32'h5);
    wr(7'h70, 32'h2);
    check("R9 chipSel 010", 32'(chipSel), 32'h2);
    expectRd("R9 select readback", 7'h70, 32'h2);

    // R11 keyed reset
    wr(7'h60, 32'h100);
    wr(7'h68, 32'h77); wr(7'h68, 32'h78);
    wr(7'h40, 32'h5);
    check("R11 wrong key keeps select", 32'(chipSel), 32'h2);
    expectRd("R11 wrong key keeps ctrl", 7'h60, 32'h100);
    expectRd("R11 wrong key keeps queue", 7'h74, 32'h1);
    s0 = startCnt;
    wr(7'h40, 32'hA);
    check("R11 select reset", 32'(chipSel), 32'h7);
    expectRd("R11 ctrl reset", 7'h60, 32'h0);
    expectRd("R11 status reset", 7'h64, 32'h5);
    expectRd("R11 txocc reset", 7'h74, 32'h0);
    idle(6);
    check("R11 queue emptied", 32'(startCnt), 32'(s0));

    // R12: every start closed before the next
    check("R12 stored plus dropped equals starts", 32'(storedCnt + overrunCnt), 32'(startCnt));

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule